// File: doc/BRIEF.md
# Debug Halt Request and Interrupt Gate

This block sits between a four-wire test access port and a processor core. It runs the usual sixteen-state test port controller on the test clock. It holds a three-bit debug control word that is loaded through a plain parallel write port in the test clock domain. From that word and two core-side signals it forms three outputs: the halt request sent to the core, the debug acknowledge shown to the rest of the system, and the interrupt enable for the core.

A request forced through the control word does not go straight to the core. It waits in a hold latch that only opens while the test port controller rests in its idle state, Run-Test/Idle. A debugger can therefore load the request into many cores while they keep running, and release all of them on the same test clock edge by moving every port into idle. After the latch, the forced request crosses into the core clock through a flop synchronizer. It is then ORed with the external request pin. The acknowledge can be forced high so that the system still sees a debug session while the core runs system-speed accesses. Interrupts are blocked whenever the combined acknowledge is high or the disable bit is set.

The write port has no handshake: a write is accepted on every test clock rising edge where the write strobe is high. The block never pushes back.

Top module: `dbgreq_gate`

## Requirements
- R1: After test reset and core reset, with both external inputs low, `dbgrq_out` is 0, `dbgack_out` is 0, `irq_en` is 1 and `tap_in_idle` is 0.
- R2: The test port controller follows the standard sixteen-state transition graph on each rising `tck` edge under `tms`. `tap_in_idle` is 1 exactly when the controller is in Run-Test/Idle.
- R3: Five consecutive `tck` rising edges with `tms` high bring the controller to Test-Logic-Reset from any state. The controller stays in that state while `tms` stays high.
- R4: On a rising `tck` edge with `ctl_we` high, the control word takes `ctl_wdata`. Bit 0 is force-acknowledge, bit 1 is force-request and bit 2 is interrupt-disable. With `ctl_we` low, the word does not change.
- R5: While the controller is outside Run-Test/Idle, a change of the force-request bit does not reach `dbgrq_out`. This holds in Shift-DR and in Pause-DR.
- R6: While the controller is in Run-Test/Idle, the hold latch follows the force-request bit. The value reaches `dbgrq_out` within `SYNC_STAGES` rising edges of `clk`. This applies both to setting the bit and to clearing it.
- R7: `dbgrq_out` is high combinationally whenever `ext_dbgrq` is high.
- R8: `dbgack_out` is the OR of `core_dbgack` and the force-acknowledge bit.
- R9: `irq_en` is 1 only when `dbgack_out` is 0 and the interrupt-disable bit is 0. Otherwise it is 0.
- R10: A low `trst_n` immediately clears the control word and the hold latch and puts the controller in Test-Logic-Reset. The cleared request then reaches `dbgrq_out` within `SYNC_STAGES` `clk` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Core-domain asynchronous reset, active low |
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test-domain asynchronous reset, active low |
| tms | input | 1 | Test mode select, steers the controller |
| ctl_we | input | 1 | Control word write strobe, sampled on `tck` rising edge |
| ctl_wdata | input | 3 | Control word write value |
| ext_dbgrq | input | 1 | External halt request |
| core_dbgack | input | 1 | Acknowledge raised by the core itself |
| dbgrq_out | output | 1 | Halt request applied to the core and driven out |
| dbgack_out | output | 1 | Debug acknowledge seen by the system |
| irq_en | output | 1 | Interrupt enable for both normal and fast interrupts |
| tap_in_idle | output | 1 | High while the controller is in Run-Test/Idle |

## Verification
The embedded assertions are checked on every cycle. They check that the hold latch keeps its value across test clock edges spent outside idle, and that the control word holds when no write is made. They also check that the controller holds in Test-Logic-Reset and in idle under the matching `tms` level, and that the external request, the core acknowledge and the blocking conditions always reach the outputs. Other behaviour shows only in the bench scenarios. These are the full eight-row interrupt truth table, and a request that is prepared during Shift-DR and Pause-DR and released only by the walk back to idle. They also include the five-high recovery from Pause-DR and the asynchronous test reset flushing a live request out through the synchronizer.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;

  localparam int CTL_W     = 3;
  localparam int CTL_FACK  = 0;
  localparam int CTL_FREQ  = 1;
  localparam int CTL_IDIS  = 2;

  typedef enum logic [3:0] {
    TS_RESET  = 4'd0,
    TS_IDLE   = 4'd1,
    TS_SEL_DR = 4'd2,
    TS_CAP_DR = 4'd3,
    TS_SHF_DR = 4'd4,
    TS_EX1_DR = 4'd5,
    TS_PAU_DR = 4'd6,
    TS_EX2_DR = 4'd7,
    TS_UPD_DR = 4'd8,
    TS_SEL_IR = 4'd9,
    TS_CAP_IR = 4'd10,
    TS_SHF_IR = 4'd11,
    TS_EX1_IR = 4'd12,
    TS_PAU_IR = 4'd13,
    TS_EX2_IR = 4'd14,
    TS_UPD_IR = 4'd15
  } tap_state_e;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import dbg_gate_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
      TS_SHF_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
      TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SHF_DR;
      TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
      TS_SHF_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
      TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SHF_IR;
      TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
      default:   nxt = TS_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= TS_RESET;
    else         state <= nxt;
  end

  // R3: held TMS keeps the controller parked in Test-Logic-Reset
  a_r3_reset_park: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_RESET && tms) |=> (state == TS_RESET));

  // R2: low TMS keeps the controller in idle
  a_r2_idle_park: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_IDLE && !tms) |=> (state == TS_IDLE));

endmodule

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg
  import dbg_gate_pkg::*;
(
  input  logic             tck,
  input  logic             trst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] ctl
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)  ctl <= '0;
    else if (we)  ctl <= wdata;
  end

  // R4: without a write strobe the control word holds
  a_r4_hold_no_write: assert property (@(posedge tck) disable iff (!trst_n)
    !we |=> $stable(ctl));

endmodule

// File: rtl/req_hold_latch.sv
module req_hold_latch (
  input  logic trst_n,
  input  logic open_en,
  input  logic d,
  output logic q
);

  always_latch begin
    if (!trst_n)      q = 1'b0;
    else if (open_en) q = d;
  end

endmodule

// File: rtl/req_sync.sv
module req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= 1'b0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[LAST];

endmodule

// File: rtl/dbgreq_gate.sv
module dbgreq_gate
  import dbg_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             ext_dbgrq,
  input  logic             core_dbgack,
  output logic             dbgrq_out,
  output logic             dbgack_out,
  output logic             irq_en,
  output logic             tap_in_idle
);

  tap_state_e       tap_st;
  logic [CTL_W-1:0] ctl;
  logic             held_req;
  logic             core_req;

  tap_fsm u_tap (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (tap_st)
  );

  assign tap_in_idle = (tap_st == TS_IDLE);

  dbg_ctl_reg u_ctl (
    .tck    (tck),
    .trst_n (trst_n),
    .we     (ctl_we),
    .wdata  (ctl_wdata),
    .ctl    (ctl)
  );

  req_hold_latch u_hold (
    .trst_n  (trst_n),
    .open_en (tap_in_idle),
    .d       (ctl[CTL_FREQ]),
    .q       (held_req)
  );

  req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (held_req),
    .q     (core_req)
  );

  assign dbgrq_out  = core_req | ext_dbgrq;
  assign dbgack_out = core_dbgack | ctl[CTL_FACK];
  assign irq_en     = ~(dbgack_out | ctl[CTL_IDIS]);

  // R5: the hold latch keeps its value across edges spent outside idle
  a_r5_latch_closed: assert property (@(posedge tck) disable iff (!trst_n)
    (!tap_in_idle && !$past(tap_in_idle)) |-> $stable(held_req));

  always_comb begin
    // R7: external request always reaches the core
    a_r7_ext_pass: assert (!ext_dbgrq || dbgrq_out);
    // R8: the core's own acknowledge is never masked
    a_r8_ack_pass: assert (!core_dbgack || dbgack_out);
    // R9: any blocking condition removes the interrupt enable
    a_r9_irq_block: assert (!(core_dbgack || ctl[CTL_FACK] || ctl[CTL_IDIS]) || !irq_en);
  end

endmodule

// File: tb/sim_dbgreq_gate.sv
module sim_dbgreq_gate;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic       tms = 1'b1;
  logic       ctl_we = 1'b0;
  logic [2:0] ctl_wdata = 3'b000;
  logic       ext_dbgrq = 1'b0;
  logic       core_dbgack = 1'b0;
  logic       dbgrq_out, dbgack_out, irq_en, tap_in_idle;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dbgreq_gate u0 (
    .clk(clk), .rst_n(rst_n), .tck(tck), .trst_n(trst_n), .tms(tms),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ext_dbgrq(ext_dbgrq),
    .core_dbgack(core_dbgack), .dbgrq_out(dbgrq_out), .dbgack_out(dbgack_out),
    .irq_en(irq_en), .tap_in_idle(tap_in_idle)
  );

  // {core_dbgack, force_ack, int_disable, expected dbgack_out, expected irq_en}
  localparam logic [4:0] VEC [8] = '{
    5'b000_01, 5'b001_00, 5'b010_10, 5'b011_10,
    5'b100_10, 5'b101_10, 5'b110_10, 5'b111_10
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic m, input logic we, input logic [2:0] d);
    tms = m; ctl_we = we; ctl_wdata = d;
    #10 tck = 1'b1;
    #10 tck = 1'b0;
    ctl_we = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #30 trst_n = 1'b1; rst_n = 1'b1;
    #10;
    chk("R1 dbgrq_out", dbgrq_out, 1'b0);
    chk("R1 dbgack_out", dbgack_out, 1'b0);
    chk("R1 irq_en", irq_en, 1'b1);
    chk("R1 tap_in_idle", tap_in_idle, 1'b0);

    step(1'b0, 1'b0, 3'b000);
    chk("R2 enter idle", tap_in_idle, 1'b1);

    // R8 R9: interrupt and acknowledge truth table
    for (int i = 0; i < 8; i++) begin
      core_dbgack = VEC[i][4];
      step(1'b0, 1'b1, {VEC[i][2], 1'b0, VEC[i][3]});
      #5;
      chk("R8 dbgack_out", dbgack_out, VEC[i][1]);
      chk("R9 irq_en", irq_en, VEC[i][0]);
    end
    core_dbgack = 1'b0;
    step(1'b0, 1'b1, 3'b000);

    // R4: strobe low leaves the word untouched
    step(1'b0, 1'b0, 3'b111);
    #20;
    chk("R4 no write ack", dbgack_out, 1'b0);
    chk("R4 no write irq", irq_en, 1'b1);
    chk("R4 no write req", dbgrq_out, 1'b0);

    // R2: instruction path round trip
    step(1'b1, 1'b0, 3'b000); chk("R2 sel-dr", tap_in_idle, 1'b0);
    step(1'b1, 1'b0, 3'b000);
    step(1'b0, 1'b0, 3'b000);
    step(1'b0, 1'b0, 3'b000);
    step(1'b1, 1'b0, 3'b000);
    step(1'b1, 1'b0, 3'b000); chk("R2 update-ir", tap_in_idle, 1'b0);
    step(1'b0, 1'b0, 3'b000); chk("R2 back to idle", tap_in_idle, 1'b1);

    // R5: request prepared in Shift-DR and Pause-DR stays hidden
    step(1'b1, 1'b0, 3'b000);
    step(1'b0, 1'b0, 3'b000);
    step(1'b0, 1'b0, 3'b000);
    step(1'b0, 1'b1, 3'b010);
    #40 chk("R5 hidden in shift-dr", dbgrq_out, 1'b0);
    step(1'b1, 1'b0, 3'b000);
    step(1'b0, 1'b0, 3'b000);
    step(1'b0, 1'b0, 3'b000);
    #40 chk("R5 hidden in pause-dr", dbgrq_out, 1'b0);
    step(1'b1, 1'b0, 3'b000);
    step(1'b1, 1'b0, 3'b000);
    #20 chk("R5 hidden in update-dr", dbgrq_out, 1'b0);
    step(1'b0, 1'b0, 3'b000);
    #20 chk("R6 released in idle", dbgrq_out, 1'b1);

    // R6: clearing in idle drops the request
    step(1'b0, 1'b1, 3'b000);
    #20 chk("R6 cleared in idle", dbgrq_out, 1'b0);

    // R7: external request passes straight through
    ext_dbgrq = 1'b1; #1;
    chk("R7 ext high", dbgrq_out, 1'b1);
    ext_dbgrq = 1'b0; #1;
    chk("R7 ext low", dbgrq_out, 1'b0);

    // R3: five high TMS from Pause-DR
    step(1'b1, 1'b0, 3'b000);
    step(1'b0, 1'b0, 3'b000);
    step(1'b0, 1'b0, 3'b000);
    step(1'b1, 1'b0, 3'b000);
    step(1'b0, 1'b0, 3'b000);
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, 3'b000);
    chk("R3 reached reset", tap_in_idle, 1'b0);
    step(1'b1, 1'b0, 3'b000);
    chk("R3 parked in reset", tap_in_idle, 1'b0);
    step(1'b0, 1'b0, 3'b000);
    chk("R3 reset to idle", tap_in_idle, 1'b1);

    // R10: test reset clears a live request
    step(1'b0, 1'b1, 3'b111);
    #20;
    chk("R10 pre req", dbgrq_out, 1'b1);
    chk("R10 pre irq", irq_en, 1'b0);
    trst_n = 1'b0; #5;
    chk("R10 ack cleared", dbgack_out, 1'b0);
    chk("R10 irq restored", irq_en, 1'b1);
    chk("R10 tap reset", tap_in_idle, 1'b0);
    #20 chk("R10 req flushed", dbgrq_out, 1'b0);
    trst_n = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule